// File: doc/BRIEF.md
# Two-Way Write-Back Data Cache

This block sits between a processor core and a backing memory. It holds recently used 64-byte lines in two ways of 64 sets. It accepts 32-bit reads and 32-bit or 64-bit stores. A store that misses still allocates a line. A modified line stays in the cache until it is evicted, and it is copied back to memory only at that point.

The core presents a request and holds it steady until `req_ready` rises. A hit completes in the same cycle it is presented. A miss stalls the core. The cache first copies out a dirty victim line, then fetches the whole target line over a line-wide memory port, then completes the access as a hit. A global enable and a per-request cacheable flag send an access straight to memory as a single 32- or 64-bit transfer, and cache contents are left alone.

The victim on a miss is a lone invalid way if there is one. Otherwise it is the way numbered by the XOR of the two per-way replacement bits. Every use of a way rewrites its own replacement bit so that the XOR next names the other way.

Top module: `wb_dcache`

## Requirements
- R1: After a synchronous active-high reset, every line is invalid and clean, with its replacement bit at 0. `req_ready` and `mem_valid` are low while no request is pending. The first cached access to any set misses and fetches the line with no write-back.
- R2: Address bits [5:0] select the byte within a line, bits [11:6] select the set and bits [31:12] form the tag. Two addresses with the same set and different tags compete for the two ways of that set.
- R3: A cached access whose tag matches a valid way completes in the cycle it is presented, with `req_ready` high and no memory request. A read returns the 32-bit little-endian word at the byte offset. `req_ready` is never high without `req_valid`.
- R4: On a miss, if exactly one way of the set is invalid, that way is the victim. Otherwise the victim is way (rep0 XOR rep1).
- R5: A victim that is valid and dirty is written to memory first, as one 64-byte line write at the address formed from its own tag and the set. The fill request for the same set follows immediately.
- R6: The fill reads 64 bytes from the line-aligned address of the request into the victim way and marks it valid and clean. A clean victim causes no write. The access then completes as a hit. A pending store is merged into the line and the line is marked dirty.
- R7: A store hit writes 4 bytes (word store, offset a multiple of 4) or 8 bytes (`req_dword`=1, offset a multiple of 8) at the offset, marks the line dirty and makes no memory request. The other bytes of the line keep their values.
- R8: When `cache_en` is 0 or `req_cacheable` is 0, the request becomes one memory transfer with `mem_line`=0 at the request address, with `mem_dword` giving the store size and data in `mem_wdata[63:0]`. A read returns `mem_rdata[31:0]`. Tags, data and replacement bits are unchanged.
- R9: `req_ready` stays low during line transfers. A memory request keeps its address and direction until `mem_ready` is sampled high.
- R10: After a hit or fill in way 0, rep0 becomes NOT rep1. After one in way 1, rep1 becomes rep0. The next two-valid miss in that set therefore evicts the way not used last.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cache_en | input | 1 | Global cache enable; 0 sends every request to memory |
| req_valid | input | 1 | Core request present, held until accepted |
| req_write | input | 1 | 1 store, 0 read |
| req_dword | input | 1 | Store size: 1 means 64-bit, 0 means 32-bit |
| req_cacheable | input | 1 | Request may use the cache |
| req_addr | input | 32 | Byte address, naturally aligned |
| req_wdata | input | 64 | Store data, bytes in little-endian order |
| req_ready | output | 1 | Request completes on this clock edge |
| req_rdata | output | 32 | Read data, valid with req_ready |
| mem_valid | output | 1 | Memory request present |
| mem_write | output | 1 | 1 write, 0 read |
| mem_line | output | 1 | 1 for a 64-byte line transfer, 0 for a single transfer |
| mem_dword | output | 1 | Size of a single transfer store |
| mem_addr | output | 32 | Memory byte address |
| mem_wdata | output | 512 | Write data: a line, or a single transfer in bits [63:0] |
| mem_ready | input | 1 | Memory completes the request on this edge |
| mem_rdata | input | 512 | Read data: a line, or a word in bits [31:0] |

## Verification
The bench aims at full sets. It runs a conflict chain in one set in which the victim must alternate. A wrong XOR or a missing replacement-bit update would evict the line just used, which shows up as an extra fill and a wrong write-back address. Stores that miss into a dirty set are checked against the evicted line's contents. A design that fetched before writing back, or wrote back to the new tag's address, would leave memory stale and later refills would return the wrong data. Uncached writes to a cached address are followed by cached reads that must still hit with the old bytes, which catches a bypass that disturbed tags or data.

// File: rtl/wbc_pkg.sv
package wbc_pkg;

    parameter int ADDR_W     = 32;
    parameter int OFFS_W     = 6;
    parameter int SET_W      = 6;
    parameter int NUM_WAYS   = 2;
    parameter int WORD_W     = 32;
    parameter int DWORD_W    = 64;

    localparam int NUM_SETS   = 1 << SET_W;
    localparam int LINE_BYTES = 1 << OFFS_W;
    localparam int LINE_W     = LINE_BYTES * 8;
    localparam int TAG_W      = ADDR_W - SET_W - OFFS_W;
    localparam int STRB_W     = DWORD_W / 8;

    typedef logic [TAG_W-1:0]  tag_t;
    typedef logic [SET_W-1:0]  set_t;
    typedef logic [OFFS_W-1:0] offs_t;
    typedef logic [LINE_W-1:0] line_t;

    typedef struct packed {
        logic valid;
        logic dirty;
        logic rep;
        tag_t tag;
    } tag_ent_t;

    typedef tag_ent_t [NUM_WAYS-1:0] tag_pair_t;
    typedef line_t    [NUM_WAYS-1:0] line_pair_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WBACK,
        ST_FILL,
        ST_DIRECT
    } ctl_state_e;

    function automatic tag_t tag_of(logic [ADDR_W-1:0] a);
        return a[ADDR_W-1 -: TAG_W];
    endfunction

    function automatic set_t set_of(logic [ADDR_W-1:0] a);
        return a[OFFS_W +: SET_W];
    endfunction

    // Lone invalid way wins; otherwise the replacement bits decide.
    function automatic logic pick_victim(tag_pair_t p);
        if (!p[0].valid && p[1].valid) return 1'b0;
        if (p[0].valid && !p[1].valid) return 1'b1;
        return p[0].rep ^ p[1].rep;
    endfunction

    // After using way w, rep0^rep1 must point at the other way.
    function automatic tag_pair_t touch_way(tag_pair_t p, logic w);
        tag_pair_t r = p;
        if (w) r[1].rep = p[0].rep;
        else   r[0].rep = ~p[1].rep;
        return r;
    endfunction

endpackage

// File: rtl/wbc_tag_store.sv
module wbc_tag_store
    import wbc_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  set_t      rd_set,
    output tag_pair_t rd_pair,
    input  logic      wr_en,
    input  set_t      wr_set,
    input  tag_pair_t wr_pair
);

    tag_pair_t tags_q [NUM_SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < NUM_SETS; s++) begin
                tags_q[s] <= '0;
            end
        end else if (wr_en) begin
            tags_q[wr_set] <= wr_pair;
        end
    end

    assign rd_pair = tags_q[rd_set];

endmodule

// File: rtl/wbc_data_store.sv
module wbc_data_store
    import wbc_pkg::*;
(
    input  logic                  clk,
    input  set_t                  rd_set,
    output line_pair_t            rd_lines,
    input  logic                  wr_en,
    input  logic                  wr_way,
    input  set_t                  wr_set,
    input  line_t                 wr_line,
    input  logic [LINE_BYTES-1:0] wr_be
);

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        line_t lines_q [NUM_SETS];
        logic  sel;

        assign sel = wr_en && (wr_way == 1'(w));

        always_ff @(posedge clk) begin
            if (sel) begin
                for (int b = 0; b < LINE_BYTES; b++) begin
                    if (wr_be[b]) begin
                        lines_q[wr_set][b*8 +: 8] <= wr_line[b*8 +: 8];
                    end
                end
            end
        end

        assign rd_lines[w] = lines_q[rd_set];
    end

endmodule

// File: rtl/wbc_ctrl.sv
module wbc_ctrl
    import wbc_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cache_en,
    input  logic                  req_valid,
    input  logic                  req_write,
    input  logic                  req_dword,
    input  logic                  req_cacheable,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [DWORD_W-1:0]    req_wdata,
    output logic                  req_ready,
    output logic [WORD_W-1:0]     req_rdata,
    output logic                  mem_valid,
    output logic                  mem_write,
    output logic                  mem_line,
    output logic                  mem_dword,
    output logic [ADDR_W-1:0]     mem_addr,
    output line_t                 mem_wdata,
    input  logic                  mem_ready,
    input  line_t                 mem_rdata,
    output set_t                  look_set,
    input  tag_pair_t             look_pair,
    input  line_pair_t            look_lines,
    output logic                  tag_wr_en,
    output tag_pair_t             tag_wr_pair,
    output logic                  data_wr_en,
    output logic                  data_wr_way,
    output line_t                 data_wr_line,
    output logic [LINE_BYTES-1:0] data_wr_be
);

    ctl_state_e state_q, state_d;
    logic       vic_q, vic_d;

    set_t  req_set;
    tag_t  req_tag;
    offs_t req_off;
    logic  use_cache;

    assign req_set   = set_of(req_addr);
    assign req_tag   = tag_of(req_addr);
    assign req_off   = req_addr[OFFS_W-1:0];
    assign use_cache = cache_en && req_cacheable;
    assign look_set  = req_set;

    logic [NUM_WAYS-1:0] way_hit;
    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_cmp
        assign way_hit[w] = look_pair[w].valid && (look_pair[w].tag == req_tag);
    end

    logic any_hit, hit_way;
    assign any_hit = |way_hit;
    assign hit_way = way_hit[1];

    logic [DWORD_W-1:0]    lane;
    line_t                 store_line;
    logic [LINE_BYTES-1:0] store_be;
    line_t                 hit_line;
    logic [WORD_W-1:0]     hit_word;

    assign lane       = req_dword ? req_wdata : {2{req_wdata[WORD_W-1:0]}};
    assign store_line = {(LINE_BYTES/STRB_W){lane}};
    assign store_be   = {{(LINE_BYTES-STRB_W){1'b0}},
                         (req_dword ? {STRB_W{1'b1}}
                                    : {{(STRB_W/2){1'b0}}, {(STRB_W/2){1'b1}}})} << req_off;
    assign hit_line   = look_lines[hit_way];
    assign hit_word   = hit_line[{req_off, 3'b000} +: WORD_W];

    tag_pair_t upd;

    always_comb begin
        state_d      = state_q;
        vic_d        = vic_q;
        req_ready    = 1'b0;
        req_rdata    = hit_word;
        mem_valid    = 1'b0;
        mem_write    = 1'b0;
        mem_line     = 1'b0;
        mem_dword    = 1'b0;
        mem_addr     = req_addr;
        mem_wdata    = store_line;
        upd          = look_pair;
        tag_wr_en    = 1'b0;
        tag_wr_pair  = look_pair;
        data_wr_en   = 1'b0;
        data_wr_way  = hit_way;
        data_wr_line = store_line;
        data_wr_be   = store_be;

        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    if (!use_cache) begin
                        state_d = ST_DIRECT;
                    end else if (any_hit) begin
                        req_ready = 1'b1;
                        upd       = touch_way(look_pair, hit_way);
                        if (req_write) begin
                            upd[hit_way].dirty = 1'b1;
                            data_wr_en         = 1'b1;
                        end
                        tag_wr_en   = 1'b1;
                        tag_wr_pair = upd;
                    end else begin
                        vic_d = pick_victim(look_pair);
                        if (look_pair[vic_d].valid && look_pair[vic_d].dirty) begin
                            state_d = ST_WBACK;
                        end else begin
                            state_d = ST_FILL;
                        end
                    end
                end
            end
            ST_WBACK: begin
                mem_valid = 1'b1;
                mem_write = 1'b1;
                mem_line  = 1'b1;
                mem_addr  = {look_pair[vic_q].tag, req_set, {OFFS_W{1'b0}}};
                mem_wdata = look_lines[vic_q];
                if (mem_ready) begin
                    state_d = ST_FILL;
                end
            end
            ST_FILL: begin
                mem_valid = 1'b1;
                mem_line  = 1'b1;
                mem_addr  = {req_tag, req_set, {OFFS_W{1'b0}}};
                if (mem_ready) begin
                    upd[vic_q].valid = 1'b1;
                    upd[vic_q].dirty = 1'b0;
                    upd[vic_q].tag   = req_tag;
                    tag_wr_en        = 1'b1;
                    tag_wr_pair      = touch_way(upd, vic_q);
                    data_wr_en       = 1'b1;
                    data_wr_way      = vic_q;
                    data_wr_line     = mem_rdata;
                    data_wr_be       = '1;
                    state_d          = ST_IDLE;
                end
            end
            ST_DIRECT: begin
                mem_valid = 1'b1;
                mem_write = req_write;
                mem_dword = req_dword;
                mem_addr  = req_addr;
                mem_wdata = LINE_W'(lane);
                req_ready = mem_ready;
                req_rdata = mem_rdata[WORD_W-1:0];
                if (mem_ready) begin
                    state_d = ST_IDLE;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            vic_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            vic_q   <= vic_d;
        end
    end

endmodule

// File: rtl/wb_dcache.sv
module wb_dcache
    import wbc_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                cache_en,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic                req_dword,
    input  logic                req_cacheable,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DWORD_W-1:0]  req_wdata,
    output logic                req_ready,
    output logic [WORD_W-1:0]   req_rdata,
    output logic                mem_valid,
    output logic                mem_write,
    output logic                mem_line,
    output logic                mem_dword,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [LINE_W-1:0]   mem_wdata,
    input  logic                mem_ready,
    input  logic [LINE_W-1:0]   mem_rdata
);

    set_t                  look_set;
    tag_pair_t             look_pair;
    line_pair_t            look_lines;
    logic                  tag_wr_en;
    tag_pair_t             tag_wr_pair;
    logic                  data_wr_en;
    logic                  data_wr_way;
    line_t                 data_wr_line;
    logic [LINE_BYTES-1:0] data_wr_be;

    wbc_ctrl u_ctrl (
        .clk          (clk),
        .rst          (rst),
        .cache_en     (cache_en),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_dword    (req_dword),
        .req_cacheable(req_cacheable),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_ready    (req_ready),
        .req_rdata    (req_rdata),
        .mem_valid    (mem_valid),
        .mem_write    (mem_write),
        .mem_line     (mem_line),
        .mem_dword    (mem_dword),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ready    (mem_ready),
        .mem_rdata    (mem_rdata),
        .look_set     (look_set),
        .look_pair    (look_pair),
        .look_lines   (look_lines),
        .tag_wr_en    (tag_wr_en),
        .tag_wr_pair  (tag_wr_pair),
        .data_wr_en   (data_wr_en),
        .data_wr_way  (data_wr_way),
        .data_wr_line (data_wr_line),
        .data_wr_be   (data_wr_be)
    );

    wbc_tag_store u_tags (
        .clk    (clk),
        .rst    (rst),
        .rd_set (look_set),
        .rd_pair(look_pair),
        .wr_en  (tag_wr_en),
        .wr_set (look_set),
        .wr_pair(tag_wr_pair)
    );

    wbc_data_store u_data (
        .clk     (clk),
        .rd_set  (look_set),
        .rd_lines(look_lines),
        .wr_en   (data_wr_en),
        .wr_way  (data_wr_way),
        .wr_set  (look_set),
        .wr_line (data_wr_line),
        .wr_be   (data_wr_be)
    );

endmodule

// File: rtl/wb_dcache_checks.sv
module wb_dcache_checks
    import wbc_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic              mem_valid,
    input logic              mem_write,
    input logic              mem_line,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              tag_wr_en
);

    assert_burst_stall_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_line) |-> !req_ready);

    assert_mem_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_ready) |=>
            (mem_valid && $stable(mem_addr) && $stable(mem_write) && $stable(mem_line)));

    assert_wb_then_fill_R5: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && mem_line && mem_write && mem_ready) |=>
            (mem_valid && mem_line && !mem_write &&
             (mem_addr[OFFS_W +: SET_W] == $past(mem_addr[OFFS_W +: SET_W]))));

    assert_bypass_keeps_tags_R8: assert property (@(posedge clk) disable iff (rst)
        (mem_valid && !mem_line) |-> !tag_wr_en);

    assert_fill_then_hit_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && mem_valid && mem_line && !mem_write && mem_ready) |=>
            (!req_valid || req_ready));

    assert_no_spurious_ready_R3: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> !req_ready);

endmodule

bind wb_dcache wb_dcache_checks u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .mem_valid(mem_valid),
    .mem_write(mem_write),
    .mem_line (mem_line),
    .mem_ready(mem_ready),
    .mem_addr (mem_addr),
    .tag_wr_en(tag_wr_en)
);

// File: tb/wb_dcache_tb.sv
`timescale 1ns/1ps
module wb_dcache_tb;
    import wbc_pkg::*;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst, cache_en, req_valid, req_write, req_dword, req_cacheable;
    logic [31:0]  req_addr;
    logic [63:0]  req_wdata;
    logic         req_ready;
    logic [31:0]  req_rdata;
    logic         mem_valid, mem_write, mem_line, mem_dword, mem_ready;
    logic [31:0]  mem_addr;
    logic [511:0] mem_wdata, mem_rdata;

    wb_dcache u_dut (.*);

    int checks = 0;
    int fails  = 0;
    localparam int LAT = 2;

    typedef struct {
        bit           wr;
        bit           line;
        bit           dw;
        logic [31:0]  addr;
        logic [511:0] data;
    } xfer_t;
    xfer_t exp_q[$];

    logic [7:0] bmem [int unsigned];

    logic [511:0] m_line  [2][64];
    logic [19:0]  m_tag   [2][64];
    bit           m_val   [2][64];
    bit           m_dirty [2][64];
    bit           m_rep   [2][64];

    function automatic logic [7:0] mem_byte(int unsigned a);
        if (bmem.exists(a)) return bmem[a];
        return 8'(a * 7 + (a >> 8) * 13 + 32'h5a);
    endfunction

    function automatic logic [31:0] mk_addr(int tg, int st, int off);
        return {20'(tg), 6'(st), 6'(off)};
    endfunction

    task automatic chk(bit ok, string rq, string what, logic [511:0] act, logic [511:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
        end
    endtask

    task automatic serve();
        xfer_t e;
        int    n;
        logic [63:0] wlow;
        if (exp_q.size() == 0) begin
            chk(0, "R3", "unexpected memory request", {mem_write, mem_line, mem_addr}, 0);
        end else begin
            e = exp_q.pop_front();
            chk(mem_write == e.wr && mem_line == e.line && mem_addr == e.addr &&
                (e.line || !e.wr || mem_dword == e.dw),
                e.line ? (e.wr ? "R5" : "R6") : "R8", "memory request",
                {mem_write, mem_line, mem_addr}, {e.wr, e.line, e.addr});
            if (e.wr) begin
                wlow = mem_dword ? mem_wdata[63:0] : {32'b0, mem_wdata[31:0]};
                chk(e.line ? (mem_wdata == e.data) : (wlow == e.data[63:0]),
                    e.line ? "R5" : "R8", "write data",
                    e.line ? mem_wdata : 512'(wlow), e.data);
            end
        end
        n = mem_line ? 64 : (mem_dword ? 8 : 4);
        if (mem_write) begin
            for (int b = 0; b < n; b++) bmem[mem_addr + b] = mem_wdata[b*8 +: 8];
        end else begin
            mem_rdata = '0;
            for (int b = 0; b < n; b++) mem_rdata[b*8 +: 8] = mem_byte(mem_addr + b);
        end
    endtask

    task automatic touch(int w, int st);
        if (w == 1) m_rep[1][st] = m_rep[0][st];
        else        m_rep[0][st] = !m_rep[1][st];
    endtask

    // Called at a negative edge.
    task automatic do_req(bit wr, bit dw, bit cach, logic [31:0] a, logic [63:0] wd, string rq);
        int st  = int'(a[11:6]);
        int off = int'(a[5:0]);
        logic [19:0] tg = a[31:12];
        bit bypass = !(cache_en && cach);
        bit exp_hit = 0;
        logic [31:0] exp_rd;
        int w, cyc, wait_cnt;
        bit done;
        xfer_t x;
        exp_q.delete();
        if (bypass) begin
            x.wr = wr; x.line = 0; x.dw = dw; x.addr = a;
            x.data = dw ? 512'(wd) : 512'(wd[31:0]);
            if (wr) exp_q.push_back(x);
            else begin x.data = '0; exp_q.push_back(x); end
            exp_rd = {mem_byte(a+3), mem_byte(a+2), mem_byte(a+1), mem_byte(a)};
        end else begin
            w = -1;
            for (int i = 0; i < 2; i++) if (m_val[i][st] && m_tag[i][st] == tg) w = i;
            exp_hit = (w >= 0);
            if (w < 0) begin
                if (!m_val[0][st] && m_val[1][st])      w = 0;
                else if (m_val[0][st] && !m_val[1][st]) w = 1;
                else                                    w = int'(m_rep[0][st] ^ m_rep[1][st]);
                if (m_val[w][st] && m_dirty[w][st]) begin
                    x.wr = 1; x.line = 1; x.dw = 0;
                    x.addr = {m_tag[w][st], 6'(st), 6'b0};
                    x.data = m_line[w][st];
                    exp_q.push_back(x);
                end
                x.wr = 0; x.line = 1; x.dw = 0; x.addr = {tg, 6'(st), 6'b0}; x.data = '0;
                exp_q.push_back(x);
                for (int b = 0; b < 64; b++) m_line[w][st][b*8 +: 8] = mem_byte(x.addr + b);
                m_val[w][st] = 1; m_dirty[w][st] = 0; m_tag[w][st] = tg;
            end
            touch(w, st);
            exp_rd = m_line[w][st][off*8 +: 32];
            if (wr) begin
                for (int b = 0; b < (dw ? 8 : 4); b++) m_line[w][st][(off+b)*8 +: 8] = wd[b*8 +: 8];
                m_dirty[w][st] = 1;
            end
        end
        req_write = wr; req_dword = dw; req_cacheable = cach; req_addr = a; req_wdata = wd;
        req_valid = 1;
        cyc = 0; done = 0; wait_cnt = 0;
        while (!done && cyc < 300) begin
            mem_ready = 0;
            #0.5;
            if (mem_valid) begin
                wait_cnt++;
                if (wait_cnt > LAT) begin
                    serve();
                    mem_ready = 1;
                    wait_cnt = 0;
                end
            end
            #0.5;
            if (req_ready) begin
                done = 1;
                if (!wr) chk(req_rdata == exp_rd, rq, "read data", 512'(req_rdata), 512'(exp_rd));
                chk(exp_q.size() == 0, rq, "memory transfers left at completion",
                    512'(exp_q.size()), 0);
                if (exp_hit) chk(cyc == 0, "R3", "hit latency", 512'(cyc), 0);
            end
            cyc++;
            @(negedge clk);
        end
        chk(done, "R9", "request never completed", 0, 1);
        req_valid = 0;
        mem_ready = 0;
    endtask

    task automatic show_summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R9 watchdog actual=running expected=finished");
        show_summary();
        $finish;
    end

    initial begin
        logic [31:0] a_A, a_B, a_C, a_D;
        rst = 1; cache_en = 1; req_valid = 0; req_write = 0; req_dword = 0;
        req_cacheable = 1; req_addr = 0; req_wdata = 0; mem_ready = 0; mem_rdata = '0;
        for (int w = 0; w < 2; w++)
            for (int s = 0; s < 64; s++) begin
                m_val[w][s] = 0; m_dirty[w][s] = 0; m_rep[w][s] = 0; m_tag[w][s] = '0; m_line[w][s] = '0;
            end
        repeat (4) @(posedge clk);
        rst = 0;
        @(negedge clk);
        #0.5;
        chk(!req_ready && !mem_valid, "R1", "idle outputs after reset",
            {req_ready, mem_valid}, 0);
        @(negedge clk);

        a_A = mk_addr(1, 3, 8);
        a_B = mk_addr(2, 3, 16);
        a_C = mk_addr(3, 3, 0);
        a_D = mk_addr(5, 9, 60);

        do_req(0, 0, 1, a_A, 0, "R1");                       // cold miss, fill only
        do_req(0, 0, 1, a_A, 0, "R3");                       // hit
        do_req(0, 0, 1, a_B, 0, "R4");                       // lone invalid way
        do_req(1, 0, 1, a_A, 64'h0000_0000_DEAD_BEEF, "R7"); // word store hit
        do_req(0, 0, 1, a_A, 0, "R7");
        do_req(0, 0, 1, a_A + 4, 0, "R7");                   // neighbour untouched
        do_req(1, 1, 1, a_B, 64'h1122_3344_5566_7788, "R7"); // dword store hit
        do_req(0, 0, 1, a_B + 4, 0, "R7");
        do_req(0, 0, 1, a_C, 0, "R5");                       // dirty victim
        do_req(0, 0, 1, a_A, 0, "R10");                      // other way evicted
        do_req(0, 0, 1, a_C, 0, "R10");
        do_req(1, 0, 0, a_C, 64'hCAFE_F00D, "R8");           // uncached write to cached line
        do_req(0, 0, 1, a_C, 0, "R8");                       // still hits old data
        cache_en = 0;
        do_req(0, 0, 1, a_C, 0, "R8");                       // disabled: direct read
        do_req(1, 1, 1, mk_addr(7, 3, 8), 64'hA5A5_5A5A_0F0F_F0F0, "R8");
        cache_en = 1;
        do_req(0, 0, 1, a_A, 0, "R8");
        do_req(1, 0, 1, a_D, 64'h0BAD_CAFE, "R6");           // store miss allocates
        do_req(0, 0, 1, a_D, 0, "R6");
        do_req(0, 0, 1, mk_addr(6, 9, 0), 0, "R4");
        do_req(0, 0, 1, mk_addr(8, 9, 0), 0, "R5");

        for (int i = 0; i < 400; i++) begin
            int st, tg, off;
            bit wr, dw, cach;
            st   = ($urandom % 3 == 0) ? 3 : (($urandom % 2) ? 9 : 20);
            tg   = $urandom % 5;
            wr   = $urandom % 2;
            dw   = wr && ($urandom % 2);
            off  = dw ? ($urandom % 8) * 8 : ($urandom % 16) * 4;
            cach = ($urandom % 10) != 0;
            do_req(wr, dw, cach, mk_addr(tg, st, off), {$urandom, $urandom}, "R2");
        end

        show_summary();
        $finish;
    end

endmodule